// File: doc/BRIEF.md
# Debounced One-Shot Trigger with Combinational Veto

This block turns a stream of spike strobes and a signed Q8.8 confidence word into a single trigger pulse. A shot is qualified in any cycle where the spike strobe is high and the confidence is at or above a programmable Q8.8 threshold. Only after that condition has held for a programmable number of back-to-back clock edges does the block emit a pulse. It emits one pulse per arming. A new pulse needs an explicit re-arm request, accepted only while the qualification condition is false.

A safety veto has two effects. First, while it is high, the debounce count is held at zero, so a shot cannot mature. Second, the veto feeds a gate with no registers at the output, so a pulse already registered is forced low in the very cycle the veto rises, with no clock of latency. A pulse suppressed this way still uses up the arming. All inputs are plain level or strobe signals sampled on every rising edge. There is no valid/ready handshake and no back-pressure: the producer keeps its own pace, and a spike that is not high at a sampling edge is simply not counted.

Top module: `shot_trigger`

## Requirements
- R1: While reset is asserted, and after it is released, `trig_o` is low and the block is disarmed. No pulse appears, even with a sustained qualifying input, until `rearm_i` has been accepted.
- R2: An edge qualifies when `spike_i` is 1 and `conf_i` >= `thresh_i`. Equality qualifies. A confidence one LSB below the threshold, or `spike_i` at 0, does not qualify.
- R3: When armed, the block registers a shot at the N-th consecutive qualifying edge, where N = `hold_i`. `trig_o` is high in the clock cycle that follows that edge.
- R4: A `hold_i` value of 0 behaves as 1: a single qualifying edge fires.
- R5: `trig_o` is high for exactly one clock cycle per shot, even if qualification persists.
- R6: After a shot, no further pulse is produced until `rearm_i` is sampled high at an edge where the edge does not qualify. A re-arm request at a qualifying edge is ignored.
- R7: A non-qualifying edge restarts the consecutive count from zero.
- R8: An edge at which `veto_i` is high clears the consecutive count and cannot register a shot.
- R9: `trig_o` is low in every cycle in which `veto_i` is high, combinationally in that same cycle. A registered shot that is masked this way still consumes the arming.
- R10: `conf_i` and `thresh_i` are compared as signed two's-complement Q8.8 values (bit 15 is the sign, 16'h0100 = 1.0). For example, 16'hFF00 (-1.0) is below 16'h0080 (0.5), and 16'h0000 is at or above 16'hFF00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spike_i | input | 1 | Spike strobe, sampled each edge |
| conf_i | input | CONF_W | Signed Q8.8 confidence |
| thresh_i | input | CONF_W | Signed Q8.8 firing threshold |
| hold_i | input | CNT_W | Consecutive qualifying edges needed (0 treated as 1) |
| veto_i | input | 1 | Safety veto, masks output combinationally |
| rearm_i | input | 1 | Re-arm request |
| trig_o | output | 1 | One-cycle trigger pulse |

## Verification
The bench instantiates the block with CNT_W = 4, CONF_W = 16 and signed comparison. With these settings, debounce lengths of 0, 1 and 3 are reached in a handful of cycles, and the sign boundary of the Q8.8 compare can be probed with exact threshold-equal and one-LSB-below values. The short count width keeps every debounce window, veto interruption and re-arm sequence within a few dozen cycles. This leaves room to show that a masked shot stays consumed across several later qualifying edges.

// File: rtl/shot_trigger_pkg.sv
package shot_trigger_pkg;
  // Arming state of the one-shot
  typedef enum logic {
    ARM_IDLE  = 1'b0,
    ARM_READY = 1'b1
  } arm_state_t;

  localparam int unsigned DEF_CONF_W = 16;
  localparam int unsigned DEF_CNT_W  = 8;
endpackage

// File: rtl/st_fire_qualifier.sv
module st_fire_qualifier #(
  parameter int unsigned CONF_W      = 16,
  parameter bit          SIGNED_CONF = 1'b1
) (
  input  logic              spike_i,
  input  logic [CONF_W-1:0] conf_i,
  input  logic [CONF_W-1:0] thresh_i,
  output logic              qual_o
);
  logic at_or_above;

  generate
    if (SIGNED_CONF) begin : g_signed
      assign at_or_above = ($signed(conf_i) >= $signed(thresh_i));
    end else begin : g_unsigned
      assign at_or_above = (conf_i >= thresh_i);
    end
  endgenerate

  assign qual_o = spike_i & at_or_above;
endmodule

// File: rtl/st_debounce.sv
module st_debounce #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             qual_i,
  input  logic             veto_i,
  input  logic [CNT_W-1:0] hold_i,
  output logic             mature_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] hold_eff;
  logic [CNT_W:0]   run_next;

  assign hold_eff = (hold_i == '0) ? CNT_ONE : hold_i;
  assign run_next = {1'b0, run_q} + {1'b0, CNT_ONE};

  // this edge completes the required run
  assign mature_o = qual_i & ~veto_i & (run_next >= {1'b0, hold_eff});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (veto_i || !qual_i) begin
      run_q <= '0;
    end else if (run_q != CNT_MAX) begin
      run_q <= run_next[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/st_oneshot.sv
module st_oneshot
  import shot_trigger_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mature_i,
  input  logic qual_i,
  input  logic rearm_i,
  output logic pulse_o
);
  arm_state_t arm_q;
  logic       pulse_q;
  logic       fire;

  assign fire = (arm_q == ARM_READY) & mature_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q   <= ARM_IDLE;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= fire;
      if (fire) begin
        arm_q <= ARM_IDLE;
      end else if (arm_q == ARM_IDLE && rearm_i && !qual_i) begin
        arm_q <= ARM_READY;
      end
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/st_veto_gate.sv
module st_veto_gate (
  input  logic pulse_i,
  input  logic veto_i,
  output logic trig_o
);
  // no storage on this path
  assign trig_o = pulse_i & ~veto_i;
endmodule

// File: rtl/shot_trigger.sv
module shot_trigger #(
  parameter int unsigned CONF_W      = shot_trigger_pkg::DEF_CONF_W,
  parameter int unsigned CNT_W       = shot_trigger_pkg::DEF_CNT_W,
  parameter bit          SIGNED_CONF = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spike_i,
  input  logic [CONF_W-1:0] conf_i,
  input  logic [CONF_W-1:0] thresh_i,
  input  logic [CNT_W-1:0]  hold_i,
  input  logic              veto_i,
  input  logic              rearm_i,
  output logic              trig_o
);
  logic qual;
  logic mature;
  logic pulse;

  st_fire_qualifier #(.CONF_W(CONF_W), .SIGNED_CONF(SIGNED_CONF)) qual_i (
    .spike_i (spike_i),
    .conf_i  (conf_i),
    .thresh_i(thresh_i),
    .qual_o  (qual)
  );

  st_debounce #(.CNT_W(CNT_W)) deb_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .qual_i  (qual),
    .veto_i  (veto_i),
    .hold_i  (hold_i),
    .mature_o(mature)
  );

  st_oneshot shot_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .mature_i(mature),
    .qual_i  (qual),
    .rearm_i (rearm_i),
    .pulse_o (pulse)
  );

  st_veto_gate gate_i (
    .pulse_i(pulse),
    .veto_i (veto_i),
    .trig_o (trig_o)
  );
endmodule

// File: rtl/st_trigger_chk.sv
module st_trigger_chk #(
  parameter int unsigned CONF_W      = 16,
  parameter bit          SIGNED_CONF = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spike_i,
  input logic [CONF_W-1:0] conf_i,
  input logic [CONF_W-1:0] thresh_i,
  input logic              veto_i,
  input logic              trig_o
);
  logic qual_seen;
  assign qual_seen = spike_i & (SIGNED_CONF ? ($signed(conf_i) >= $signed(thresh_i))
                                            : (conf_i >= thresh_i));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> !trig_o);

  // R9
  veto_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    veto_i |-> !trig_o);

  // R5
  single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> !trig_o);

  // R2
  qualified_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> $past(qual_seen));

  // R8
  veto_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    veto_i |=> !trig_o);
endmodule

bind shot_trigger st_trigger_chk #(.CONF_W(CONF_W), .SIGNED_CONF(SIGNED_CONF)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .spike_i (spike_i),
  .conf_i  (conf_i),
  .thresh_i(thresh_i),
  .veto_i  (veto_i),
  .trig_o  (trig_o)
);

// File: tb/shot_trigger_tb_top.sv
module shot_trigger_tb_top;
  localparam int CONF_W = 16;
  localparam int CNT_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              spike = 1'b0;
  logic [CONF_W-1:0] conf = '0;
  logic [CONF_W-1:0] thresh = 16'h0180;
  logic [CNT_W-1:0]  hold = 4'd3;
  logic              veto = 1'b0;
  logic              rearm = 1'b0;
  logic              trig;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  item_t sb[$];
  int    vectors = 0;
  int    fails = 0;
  bit    done = 1'b0;

  always #5 clk = ~clk;

  shot_trigger #(.CONF_W(CONF_W), .CNT_W(CNT_W), .SIGNED_CONF(1'b1)) dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .spike_i (spike),
    .conf_i  (conf),
    .thresh_i(thresh),
    .hold_i  (hold),
    .veto_i  (veto),
    .rearm_i (rearm),
    .trig_o  (trig)
  );

  task automatic drive(input logic sp, input logic [CONF_W-1:0] cf, input logic vt,
                       input logic ra, input logic exp, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    spike = sp; conf = cf; veto = vt; rearm = ra;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic q(input logic exp, input string tag);
    drive(1'b1, 16'h0200, 1'b0, 1'b0, exp, tag);
  endtask

  task automatic idle(input logic exp, input string tag);
    drive(1'b0, 16'h0000, 1'b0, 1'b0, exp, tag);
  endtask

  task automatic rearm_cycle(input string tag);
    drive(1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, tag);
  endtask

  // monitor: compare each cycle away from the rising edge
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        it = sb.pop_front();
        vectors++;
        if (trig !== it.exp) begin
          fails++;
          $display("FAIL %s: trig_o=%0b expected %0b", it.tag, trig, it.exp);
        end
      end
    end
  end

  initial begin
    // R1: quiet during reset
    idle(1'b0, "R1 in reset");
    idle(1'b0, "R1 in reset");
    @(posedge clk); #1 rst_n = 1'b1;
    // R1: disarmed after reset, sustained qualification ignored
    for (int i = 0; i < 5; i++) q(1'b0, "R1 disarmed");
    rearm_cycle("R1 rearm");
    // R3: hold=3, fire after the third qualifying edge
    q(1'b0, "R3 edge1");
    q(1'b0, "R3 edge2");
    q(1'b0, "R3 edge3");
    q(1'b1, "R3 pulse");
    q(1'b0, "R5 single cycle");
    q(1'b0, "R5 single cycle");
    // R6: rearm while qualifying is ignored
    drive(1'b1, 16'h0200, 1'b0, 1'b1, 1'b0, "R6 rearm ignored");
    idle(1'b0, "R6");
    for (int i = 0; i < 4; i++) q(1'b0, "R6 still disarmed");
    rearm_cycle("R6 rearm");
    // R7: a gap restarts the run
    q(1'b0, "R7 run a1");
    q(1'b0, "R7 run a2");
    idle(1'b0, "R7 gap");
    q(1'b0, "R7 run b1");
    q(1'b0, "R7 run b2");
    q(1'b0, "R7 run b3");
    idle(1'b1, "R7 pulse");
    rearm_cycle("R7 rearm");
    // R8: veto clears the run
    q(1'b0, "R8 v1");
    drive(1'b1, 16'h0200, 1'b1, 1'b0, 1'b0, "R8 veto edge");
    q(1'b0, "R8 w1");
    q(1'b0, "R8 w2");
    q(1'b0, "R8 w3");
    idle(1'b1, "R8 pulse");
    rearm_cycle("R8 rearm");
    // R9: veto masks registered pulse, shot consumed
    q(1'b0, "R9 x1");
    q(1'b0, "R9 x2");
    q(1'b0, "R9 x3");
    drive(1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, "R9 veto masks pulse");
    idle(1'b0, "R9 no late pulse");
    for (int i = 0; i < 4; i++) q(1'b0, "R9 shot consumed");
    rearm_cycle("R9 rearm");
    hold = 4'd0;
    // R4: hold 0 acts as 1
    q(1'b0, "R4 single edge");
    idle(1'b1, "R4 pulse");
    rearm_cycle("R4 rearm");
    // R2: equality qualifies
    drive(1'b1, 16'h0180, 1'b0, 1'b0, 1'b0, "R2 equal");
    idle(1'b1, "R2 equal fires");
    rearm_cycle("R2 rearm");
    // R2: one LSB below and spike low do not qualify
    drive(1'b1, 16'h017F, 1'b0, 1'b0, 1'b0, "R2 below");
    drive(1'b1, 16'h017F, 1'b0, 1'b0, 1'b0, "R2 below");
    idle(1'b0, "R2 below no fire");
    drive(1'b0, 16'h0200, 1'b0, 1'b0, 1'b0, "R2 no spike");
    drive(1'b0, 16'h0200, 1'b0, 1'b0, 1'b0, "R2 no spike");
    idle(1'b0, "R2 no spike no fire");
    thresh = 16'h0080;
    // R10: -1.0 is below 0.5
    drive(1'b1, 16'hFF00, 1'b0, 1'b0, 1'b0, "R10 negative conf");
    idle(1'b0, "R10 negative conf no fire");
    thresh = 16'hFF00;
    // R10: 0.0 is above -1.0
    drive(1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, "R10 negative thresh");
    idle(1'b1, "R10 negative thresh fires");
    idle(1'b0, "R10 tail");
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (2000) @(posedge clk);
        if (!done) begin
          fails++;
          $display("FAIL watchdog: run incomplete, expected done");
        end
      end
    join_any
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule